// File: doc/BRIEF.md
# Dual-Scan Monochrome Panel Timing Generator

This block refreshes a 1-bit-per-pixel monochrome flat panel. The panel has a parallel interface and is scanned in two halves at once. One 4-bit bus carries pixels for the top half of the screen. A second 4-bit bus carries pixels for the bottom half, which begins at the middle row. Both buses share one pixel clock. Each clock period delivers four pixels to each half, so every line period refreshes one row in each half. The panel holds no image, so the block refreshes it continuously, with no blanking porches around the active data.

Pixel data arrives as two streams of 32-bit words, one stream per half, each with a valid/ready handshake. Both streams are consumed in strict lockstep: a transfer happens only when both streams offer a word, and one shared nibble index selects the same nibble from each word. At the end of every line the block generates a horizontal sync interval. The first line of each frame also carries a vertical sync pulse. A one-cycle end-of-frame pulse lets the frame source swap buffers without tearing.

Line length, lines per half, sync pulse widths and the clock divider are all parameters. The divider sets how many system cycles make up one internal tick. The defaults describe a 640x480 panel: 160 transfers per line and 240 line periods per frame. With a divider of 10 on a 100 MHz system clock the frame rate is about 120 Hz.

Top module: `dual_scan_panel_timing`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `pix_clk`, `hsync`, `vsync`, `frame_done`, `underrun` and both pixel buses are 0.
- R2: A tick lasts `CLK_DIV` system cycles. Each transfer drives `pix_clk` high for exactly one tick while a new nibble pair is placed on the buses. `pix_clk` is then low for at least one tick, and the nibbles stay unchanged while `pix_clk` is high.
- R3: Each 32-bit word gives 8 transfers, starting with bits [3:0] and ending with bits [31:28]. Words run on continuously across line and frame boundaries. `upper_ready` and `lower_ready` pulse in the cycle where the eighth nibble of a word is taken.
- R4: The two buses move in lockstep. `upper_ready` and `lower_ready` are always equal, and a transfer happens only when both `upper_valid` and `lower_valid` are high.
- R5: After `LINE_XFERS` transfers, a sync interval follows: `hsync` is high for `HS_HIGH` ticks, then low for `HS_LOW` ticks. Throughout this interval `pix_clk` is low and both buses are 0.
- R6: `vsync` is high for `VS_HIGH` ticks, starting with `hsync`, only in the sync interval of the first line of each frame.
- R7: A frame is `HALF_LINES` line periods. `frame_done` is high for exactly one cycle after the sync interval of the last line.
- R8: A frame starts only while `enable` is high. When `enable` is low at a frame boundary, no transfers occur and all outputs except `underrun` stay low.
- R9: If either stream lacks data after a line has begun, the block stalls. `pix_clk` stays low, the buses hold their value, and `underrun` goes high and stays high until reset.
- R10: At the start of a line, the block waits without flagging an underrun until both streams are valid. No word is consumed from either stream while only one of them is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows a new frame to start |
| upper_data | input | 32 | Top-half pixel word, low nibble first |
| upper_valid | input | 1 | Top-half word available |
| upper_ready | output | 1 | Top-half word consumed this cycle |
| lower_data | input | 32 | Bottom-half pixel word, low nibble first |
| lower_valid | input | 1 | Bottom-half word available |
| lower_ready | output | 1 | Bottom-half word consumed this cycle |
| pix_up | output | 4 | Top-half pixel bus |
| pix_lo | output | 4 | Bottom-half pixel bus |
| pix_clk | output | 1 | Shared pixel clock |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync, on the first line only |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| underrun | output | 1 | Sticky mid-line data shortage flag |

## Verification
The bench feeds the datapath with words that have distinct nibbles in both halves, so a swapped bus, a reversed nibble order or a lost word shows up as a pair mismatch.

It runs three supply patterns:
- A stream that ends exactly at a line boundary, which must cause a quiet wait.
- A stream that ends partway through a line, which must stall the buses and set the sticky flag.
- A case where only the upper stream is valid, which must hold both buses still.

Frames run with the enable held high and then dropped partway through a frame. These runs separate correct frame gating from a frame that starts too early or does not stop.

// File: rtl/dual_scan_panel_timing.sv
module dual_scan_panel_timing #(
  parameter int LINE_XFERS = 160,
  parameter int HALF_LINES = 240,
  parameter int HS_HIGH    = 6,
  parameter int HS_LOW     = 10,
  parameter int VS_HIGH    = 7,
  parameter int CLK_DIV    = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic [31:0] upper_data,
  input  logic        upper_valid,
  output logic        upper_ready,
  input  logic [31:0] lower_data,
  input  logic        lower_valid,
  output logic        lower_ready,
  output logic [3:0]  pix_up,
  output logic [3:0]  pix_lo,
  output logic        pix_clk,
  output logic        hsync,
  output logic        vsync,
  output logic        frame_done,
  output logic        underrun
);
  localparam int SYNC_LEN = HS_HIGH + HS_LOW;
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int XW = $clog2(LINE_XFERS + 1);
  localparam int LW = (HALF_LINES > 1) ? $clog2(HALF_LINES) : 1;
  localparam int SW = $clog2(SYNC_LEN + 1);

  logic [DW-1:0] div_q;
  logic [XW-1:0] xcnt_q;
  logic [LW-1:0] line_q;
  logic [SW-1:0] scnt_q;
  logic [2:0]    nib_q;
  logic          hi_q, sync_q;
  logic          tick, line_full, gate_ok, fire;

  assign tick      = (div_q == DW'(CLK_DIV - 1));
  assign line_full = (xcnt_q == XW'(LINE_XFERS));
  assign gate_ok   = (xcnt_q != '0) || (line_q != '0) || enable;
  assign fire      = tick && !hi_q && !sync_q && !line_full &&
                     upper_valid && lower_valid && gate_ok;

  assign upper_ready = fire && (nib_q == 3'd7);
  assign lower_ready = upper_ready;
  assign pix_clk     = hi_q;
  assign hsync       = sync_q && (scnt_q < SW'(HS_HIGH));
  assign vsync       = sync_q && (line_q == '0) && (scnt_q < SW'(VS_HIGH));

  always_ff @(posedge clk) begin
    if (rst || tick) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xcnt_q <= '0; line_q <= '0; scnt_q <= '0; nib_q <= '0;
      hi_q <= 1'b0; sync_q <= 1'b0; frame_done <= 1'b0; underrun <= 1'b0;
      pix_up <= '0; pix_lo <= '0;
    end else begin
      frame_done <= 1'b0;
      if (tick) begin
        if (hi_q) begin
          hi_q <= 1'b0;
        end else if (sync_q) begin
          if (scnt_q == SW'(SYNC_LEN - 1)) begin
            sync_q <= 1'b0;
            scnt_q <= '0;
            xcnt_q <= '0;
            if (line_q == LW'(HALF_LINES - 1)) begin
              line_q     <= '0;
              frame_done <= 1'b1;
            end else begin
              line_q <= line_q + 1'b1;
            end
          end else begin
            scnt_q <= scnt_q + 1'b1;
          end
        end else if (line_full) begin
          sync_q <= 1'b1;
          scnt_q <= '0;
          pix_up <= '0;
          pix_lo <= '0;
        end else if (fire) begin
          hi_q   <= 1'b1;
          pix_up <= upper_data[{nib_q, 2'b00} +: 4];
          pix_lo <= lower_data[{nib_q, 2'b00} +: 4];
          nib_q  <= nib_q + 1'b1;
          xcnt_q <= xcnt_q + 1'b1;
        end else if (xcnt_q != '0) begin
          underrun <= 1'b1;
        end
      end
    end
  end

  // R2
  pclk_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_clk && $past(pix_clk)) |-> ($stable(pix_up) && $stable(pix_lo)));
  // R3
  ready_then_clock_chk: assert property (@(posedge clk) disable iff (rst)
    upper_ready |=> pix_clk);
  // R4
  both_valid_chk: assert property (@(posedge clk) disable iff (rst)
    upper_ready |-> (upper_valid && lower_valid));
  // R5
  sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hsync |-> (!pix_clk && pix_up == 4'd0 && pix_lo == 4'd0));
  // R6
  vsync_first_line_chk: assert property (@(posedge clk) disable iff (rst)
    vsync |-> (line_q == '0 && sync_q));
  // R7
  frame_done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
  // R9
  underrun_stall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> !pix_clk);
endmodule

// File: tb/tb_dual_scan_panel_timing.sv
module tb_dual_scan_panel_timing;
  localparam int LX = 12, HL = 3, HH = 3, HLO = 4, VH = 5, DV = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, enable, upper_valid, lower_valid, upper_ready, lower_ready;
  logic [31:0] upper_data, lower_data;
  logic [3:0] pix_up, pix_lo;
  logic pix_clk, hsync, vsync, frame_done, underrun;

  dual_scan_panel_timing #(.LINE_XFERS(LX), .HALF_LINES(HL), .HS_HIGH(HH),
    .HS_LOW(HLO), .VS_HIGH(VH), .CLK_DIV(DV)) dut (
    .clk(clk), .rst(rst), .enable(enable),
    .upper_data(upper_data), .upper_valid(upper_valid), .upper_ready(upper_ready),
    .lower_data(lower_data), .lower_valid(lower_valid), .lower_ready(lower_ready),
    .pix_up(pix_up), .pix_lo(pix_lo), .pix_clk(pix_clk), .hsync(hsync),
    .vsync(vsync), .frame_done(frame_done), .underrun(underrun));

  logic [31:0] uq[$], lq[$];
  logic [7:0]  expq[$];
  int checks = 0, fails = 0, cycles = 0;
  int rises = 0, frames = 0, xfer_line = 0, xfer_frame = 0;
  bit lo_hold = 0, pop_pend = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_word(logic [31:0] u, logic [31:0] l);
    uq.push_back(u);
    lq.push_back(l);
    for (int i = 0; i < 8; i++) expq.push_back({u[4*i +: 4], l[4*i +: 4]});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // stream sources
  initial begin
    upper_valid = 0; lower_valid = 0; upper_data = '0; lower_data = '0;
    forever begin
      @(negedge clk);
      if (pop_pend) begin
        void'(uq.pop_front());
        void'(lq.pop_front());
        pop_pend = 0;
      end
      upper_valid = uq.size() > 0;
      lower_valid = (lq.size() > 0) && !lo_hold;
      upper_data  = (uq.size() > 0) ? uq[0] : '0;
      lower_data  = (lq.size() > 0) ? lq[0] : '0;
      #1;
      if (upper_ready !== lower_ready) chk(0, "R4 ready pairing", upper_ready, lower_ready);
      if (upper_ready) pop_pend = 1;
    end
  end

  // monitor / scoreboard
  initial begin
    logic pp, ph, pv, pf;
    int hi_w, hs_w, vs_w, fe_w;
    logic [7:0] e;
    pp = 0; ph = 0; pv = 0; pf = 0; hi_w = 0; hs_w = 0; vs_w = 0; fe_w = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (!rst) begin
        if (pix_clk && !pp) begin
          rises++; xfer_line++; xfer_frame++;
          if (expq.size() == 0) chk(0, "R3 unexpected transfer", {pix_up, pix_lo}, 0);
          else begin
            e = expq.pop_front();
            chk({pix_up, pix_lo} == e, "R3 nibble pair", {pix_up, pix_lo}, e);
          end
        end
        if (!pix_clk && pp) chk(hi_w == DV, "R2 pclk high width", hi_w, DV);
        if (hsync && !ph) begin
          chk(xfer_line == LX, "R5 transfers per line", xfer_line, LX);
          xfer_line = 0;
        end
        if (!hsync && ph) chk(hs_w == HH*DV, "R5 hsync width", hs_w, HH*DV);
        if (vsync && !pv) begin
          chk(xfer_frame == LX, "R6 vsync on first line", xfer_frame, LX);
          chk(hsync, "R6 vsync starts with hsync", hsync, 1);
        end
        if (!vsync && pv) chk(vs_w == VH*DV, "R6 vsync width", vs_w, VH*DV);
        if (hsync || vsync)
          chk(!pix_clk && pix_up == 0 && pix_lo == 0, "R5 quiet sync", {pix_clk, pix_up, pix_lo}, 0);
        if (frame_done && !pf) begin
          chk(xfer_frame == LX*HL, "R7 transfers per frame", xfer_frame, LX*HL);
          frames++; xfer_frame = 0;
        end
        if (!frame_done && pf) chk(fe_w == 1, "R7 frame_done width", fe_w, 1);
      end
      hi_w = pix_clk ? hi_w + 1 : 0;
      hs_w = hsync ? hs_w + 1 : 0;
      vs_w = vsync ? vs_w + 1 : 0;
      fe_w = frame_done ? fe_w + 1 : 0;
      pp = pix_clk; ph = hsync; pv = vsync; pf = frame_done;
    end
  end

  // watchdog
  initial begin
    wait (cycles > 20000);
    chk(0, "watchdog expired", cycles, 20000);
    finish_run();
  end

  initial begin
    rst = 1; enable = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({pix_clk, hsync, vsync, frame_done, underrun, pix_up, pix_lo} == 0, "R1 reset state",
        {pix_clk, hsync, vsync, frame_done, underrun, pix_up, pix_lo}, 0);
    @(posedge clk); rst = 0;
    @(negedge clk);
    chk({pix_clk, hsync, vsync, frame_done, underrun} == 0, "R1 after release",
        {pix_clk, hsync, vsync, frame_done, underrun}, 0);

    push_word(32'h7654_3210, 32'hFEDC_BA98);
    push_word(32'hA5C3_1E69, 32'h0F1E_2D3C);
    repeat (60) @(negedge clk);
    chk(rises == 0, "R8 no frame while disabled", rises, 0);
    chk(pix_clk == 0 && hsync == 0, "R8 outputs low while disabled", {pix_clk, hsync}, 0);

    lo_hold = 1; enable = 1;
    push_word(32'h1357_9BDF, 32'h2468_ACE0);
    repeat (60) @(negedge clk);
    chk(rises == 0, "R10 wait for both streams", rises, 0);
    chk(uq.size() == 3, "R10 nothing consumed", uq.size(), 3);
    lo_hold = 0;
    wait (rises == 24);
    repeat (200) @(negedge clk);
    chk(rises == 24, "R10 wait at line start", rises, 24);
    chk(underrun == 0, "R10 no underrun at line start", underrun, 0);

    push_word(32'hC0FF_EE11, 32'h3BAD_F00D);
    repeat (200) @(negedge clk);
    chk(rises == 32, "R9 stalled mid-line", rises, 32);
    chk(underrun == 1, "R9 underrun flagged", underrun, 1);
    chk(pix_clk == 0, "R9 pclk low during stall", pix_clk, 0);

    for (int i = 0; i < 10; i++)
      push_word(32'h9E37_79B9 * (i + 3), 32'h85EB_CA6B ^ (32'h0101_0101 * i));
    wait (rises >= 80);
    enable = 0;
    wait (frames == 3);
    repeat (300) @(negedge clk);
    chk(rises == 108, "R8 frame held after enable drop", rises, 108);
    chk({pix_clk, hsync, vsync, pix_up, pix_lo} == 0, "R8 idle outputs low",
        {pix_clk, hsync, vsync, pix_up, pix_lo}, 0);
    chk(expq.size() == 4, "R3 leftover nibbles", expq.size(), 4);
    chk(underrun == 1, "R9 underrun sticky", underrun, 1);
    finish_run();
  end
endmodule